// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog that runs on its own slow clock, apart from the bus clock that software uses to reach it. Software controls it only by writing 16-bit magic values into a key register. One value unlocks the prescaler and reload registers. One value reloads the down-counter. One value starts the watchdog, and nothing but a reset stops it after that. A configuration input can also start it straight out of reset, with no key write.

A prescaler divides the slow clock by a power of two from 4 to 256. The divided clock steps a 12-bit down-counter. When that counter expires, the block issues a system reset request for one slow-clock cycle. The counter then begins again from its maximum value.

Prescaler and reload values are written on the bus side. They are carried into the slow-clock domain through a toggle handshake. A status register shows one busy flag per value while its transfer is still in flight.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the prescaler code reads 0, the reload value reads 0xFFF, the status reads 0, and the reset request is low.
- R2: Bus addresses: 0 is the key, 1 is the prescaler code (bits 2:0), 2 is the reload value (bits 11:0), and 3 is the status. Writing key 0x5555 unlocks addresses 1 and 2. Writes to them while locked leave the readback unchanged. Any key value other than 0x5555 locks them again.
- R3: Key 0xAAAA loads the counter from the reload value and locks the prescaler and reload registers.
- R4: Key 0xCCCC starts the watchdog and locks the registers. No key write stops it afterwards. Before any start, a loaded counter does not time out.
- R5: Once running, the reset request fires (R+1)*D slow-clock cycles after a reload, where R is the reload value and D is the divide ratio. Two to four further slow cycles of key synchronisation are added.
- R6: Prescaler codes 0 to 6 divide by 4, 8, 16, 32, 64, 128 and 256. Code 7 also divides by 256.
- R7: The reset request is high for exactly one slow-clock cycle. The counter then restarts from 0xFFF, so no second request follows soon after.
- R8: Status bit 0 marks a prescaler transfer in flight and bit 1 marks a reload transfer in flight. Each bit sets on an accepted write and clears after the slow-domain handshake. A write to a register whose flag is set is dropped.
- R9: With the hardware-start input high, the watchdog runs and times out without any start key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, held for several slow-clock cycles |
| sclk | input | 1 | Slow watchdog clock |
| hw_start | input | 1 | Starts the watchdog with no key write when high |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | 2 | Register select: 0 key, 1 prescaler, 2 reload, 3 status |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Readback of the selected register; the key reads 0 |
| wdg_rst_req | output | 1 | One-slow-cycle system reset request |

## Verification
The hardest condition to reach from the ports is a write that lands while the earlier transfer of the same register is still crossing into the slow domain. The stimulus writes a prescaler code, reads the status once, and writes a second code straight away. The slow clock is five bus cycles long and the handshake spans several slow cycles, so the second write falls inside the busy window every time. The readback after the flag clears shows which of the two values was kept. Timeout periods are measured in slow-clock cycles from the reload key. Each measured period must fall inside a narrow window that allows for the synchroniser latency.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int KEY_W  = 16;
    localparam int CNT_W  = 12;
    localparam int PSC_W  = 3;
    localparam int PDIV_W = 8;
    localparam int ADDR_W = 2;
    localparam int PSC_TOP_CODE = 6;

    localparam logic [KEY_W-1:0] KEY_UNLOCK = 16'h5555;
    localparam logic [KEY_W-1:0] KEY_KICK   = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_START  = 16'hCCCC;

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef enum logic [ADDR_W-1:0] {
        SEL_KEY  = 2'd0,
        SEL_PSC  = 2'd1,
        SEL_RLD  = 2'd2,
        SEL_STAT = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic rld_busy;
        logic psc_busy;
    } stat_t;

    // Terminal value of the prescale counter: divide ratio minus one.
    function automatic logic [PDIV_W-1:0] psc_terminal(input logic [PSC_W-1:0] code);
        logic [PDIV_W:0] ratio;
        int              c;
        c     = (int'(code) > PSC_TOP_CODE) ? PSC_TOP_CODE : int'(code);
        ratio = (PDIV_W+1)'(4) << c;
        return PDIV_W'(ratio - 1'b1);
    endfunction

endpackage

// File: rtl/wdg_bus_regs.sv
module wdg_bus_regs
    import wdg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  hw_start,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [KEY_W-1:0]      wdata,
    input  logic                  psc_busy,
    input  logic                  rld_busy,
    output logic [PSC_W-1:0]      psc_q,
    output logic [CNT_W-1:0]      rld_q,
    output logic                  psc_load,
    output logic                  rld_load,
    output logic                  kick_tog,
    output logic                  started,
    output logic                  unlocked
);

    reg_sel_e sel;
    logic     key_wr;

    assign sel      = reg_sel_e'(addr);
    assign key_wr   = we && (sel == SEL_KEY);
    assign psc_load = we && (sel == SEL_PSC) && unlocked && !psc_busy;
    assign rld_load = we && (sel == SEL_RLD) && unlocked && !rld_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            unlocked <= 1'b0;
            psc_q    <= '0;
            rld_q    <= CNT_MAX;
            kick_tog <= 1'b0;
            started  <= 1'b0;
        end else begin
            if (hw_start) begin
                started <= 1'b1;
            end
            if (key_wr) begin
                unlocked <= (wdata == KEY_UNLOCK);
                if (wdata == KEY_KICK) begin
                    kick_tog <= ~kick_tog;
                end
                if (wdata == KEY_START) begin
                    started <= 1'b1;
                end
            end
            if (psc_load) begin
                psc_q <= wdata[PSC_W-1:0];
            end
            if (rld_load) begin
                rld_q <= wdata[CNT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/wdg_cdc_word.sv
module wdg_cdc_word #(
    parameter int          W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic         busy,
    input  logic         sclk,
    output logic [W-1:0] dout
);

    logic req_tog, ack_b1, ack_b2;
    logic req_s1, req_s2, ack_tog;

    // Bus side: a load flips the request; busy until the ack flips back.
    always_ff @(posedge clk) begin
        if (rst) begin
            req_tog <= 1'b0;
            ack_b1  <= 1'b0;
            ack_b2  <= 1'b0;
        end else begin
            req_tog <= req_tog ^ load;
            ack_b1  <= ack_tog;
            ack_b2  <= ack_b1;
        end
    end

    assign busy = req_tog ^ ack_b2;

    // Slow side: capture the held word once the request is seen.
    always_ff @(posedge sclk) begin
        if (rst) begin
            req_s1  <= 1'b0;
            req_s2  <= 1'b0;
            ack_tog <= 1'b0;
            dout    <= RST_VAL;
        end else begin
            req_s1 <= req_tog;
            req_s2 <= req_s1;
            if (req_s2 != ack_tog) begin
                dout    <= din;
                ack_tog <= req_s2;
            end
        end
    end

endmodule

// File: rtl/wdg_count_core.sv
module wdg_count_core
    import wdg_pkg::*;
(
    input  logic             sclk,
    input  logic             rst,
    input  logic             started_b,
    input  logic             kick_tog_b,
    input  logic [PSC_W-1:0] psc_code,
    input  logic [CNT_W-1:0] rld_val,
    output logic             rst_req,
    output logic [CNT_W-1:0] cnt
);

    logic              st_s1, st_s2;
    logic              kt_s1, kt_s2, kt_s3;
    logic              kick;
    logic              tick;
    logic [PDIV_W-1:0] pcnt;
    logic [PDIV_W-1:0] lim;

    assign kick = kt_s2 ^ kt_s3;
    assign lim  = psc_terminal(psc_code);
    assign tick = (pcnt >= lim);

    always_ff @(posedge sclk) begin
        if (rst) begin
            st_s1   <= 1'b0;
            st_s2   <= 1'b0;
            kt_s1   <= 1'b0;
            kt_s2   <= 1'b0;
            kt_s3   <= 1'b0;
            pcnt    <= '0;
            cnt     <= CNT_MAX;
            rst_req <= 1'b0;
        end else begin
            st_s1   <= started_b;
            st_s2   <= st_s1;
            kt_s1   <= kick_tog_b;
            kt_s2   <= kt_s1;
            kt_s3   <= kt_s2;
            rst_req <= 1'b0;
            if (kick) begin
                cnt  <= rld_val;
                pcnt <= '0;
            end else if (st_s2) begin
                if (tick) begin
                    pcnt <= '0;
                    if (cnt == '0) begin
                        rst_req <= 1'b1;
                        cnt     <= CNT_MAX;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end else begin
                    pcnt <= pcnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import wdg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              hw_start,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [KEY_W-1:0]  bus_wdata,
    output logic [KEY_W-1:0]  bus_rdata,
    output logic              wdg_rst_req
);

    logic [PSC_W-1:0] psc_q, psc_s;
    logic [CNT_W-1:0] rld_q, rld_s;
    logic             psc_load, rld_load;
    logic             kick_tog, started, unlocked;
    logic [CNT_W-1:0] cnt;
    stat_t            stat;

    wdg_bus_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .hw_start (hw_start),
        .we       (bus_we),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .psc_busy (stat.psc_busy),
        .rld_busy (stat.rld_busy),
        .psc_q    (psc_q),
        .rld_q    (rld_q),
        .psc_load (psc_load),
        .rld_load (rld_load),
        .kick_tog (kick_tog),
        .started  (started),
        .unlocked (unlocked)
    );

    wdg_cdc_word #(.W(PSC_W), .RST_VAL('0)) u_psc_xfer (
        .clk  (clk),
        .rst  (rst),
        .load (psc_load),
        .din  (psc_q),
        .busy (stat.psc_busy),
        .sclk (sclk),
        .dout (psc_s)
    );

    wdg_cdc_word #(.W(CNT_W), .RST_VAL(CNT_MAX)) u_rld_xfer (
        .clk  (clk),
        .rst  (rst),
        .load (rld_load),
        .din  (rld_q),
        .busy (stat.rld_busy),
        .sclk (sclk),
        .dout (rld_s)
    );

    wdg_count_core u_core (
        .sclk       (sclk),
        .rst        (rst),
        .started_b  (started),
        .kick_tog_b (kick_tog),
        .psc_code   (psc_s),
        .rld_val    (rld_s),
        .rst_req    (wdg_rst_req),
        .cnt        (cnt)
    );

    always_comb begin
        case (reg_sel_e'(bus_addr))
            SEL_PSC:  bus_rdata = {{(KEY_W-PSC_W){1'b0}}, psc_q};
            SEL_RLD:  bus_rdata = {{(KEY_W-CNT_W){1'b0}}, rld_q};
            SEL_STAT: bus_rdata = {{(KEY_W-2){1'b0}}, stat};
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk
    import wdg_pkg::*;
(
    input logic              clk,
    input logic              sclk,
    input logic              rst,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [KEY_W-1:0]  bus_wdata,
    input logic              unlocked,
    input logic              started,
    input logic [PSC_W-1:0]  psc_q,
    input logic              psc_load,
    input logic              rld_load,
    input logic              psc_busy,
    input logic              rld_busy,
    input logic              wdg_rst_req,
    input logic [CNT_W-1:0]  cnt
);

    assert_locked_psc_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == SEL_PSC && !unlocked) |=> $stable(psc_q));

    assert_kick_relocks_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == SEL_KEY && bus_wdata == KEY_KICK) |=> !unlocked);

    assert_no_stop_R4: assert property (@(posedge clk) disable iff (rst)
        started |=> started);

    assert_single_pulse_R7: assert property (@(posedge sclk) disable iff (rst)
        wdg_rst_req |=> !wdg_rst_req);

    assert_restart_max_R7: assert property (@(posedge sclk) disable iff (rst)
        wdg_rst_req |-> (cnt == CNT_MAX));

    assert_psc_busy_R8: assert property (@(posedge clk) disable iff (rst)
        psc_load |=> psc_busy);

    assert_rld_busy_R8: assert property (@(posedge clk) disable iff (rst)
        rld_load |=> rld_busy);

endmodule

bind keyed_watchdog keyed_watchdog_chk u_chk (
    .clk         (clk),
    .sclk        (sclk),
    .rst         (rst),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .unlocked    (unlocked),
    .started     (started),
    .psc_q       (psc_q),
    .psc_load    (psc_load),
    .rld_load    (rld_load),
    .psc_busy    (stat.psc_busy),
    .rld_busy    (stat.rld_busy),
    .wdg_rst_req (wdg_rst_req),
    .cnt         (cnt)
);

// File: tb/keyed_watchdog_test.sv
module keyed_watchdog_test;

    logic        clk = 1'b0;
    logic        sclk = 1'b0;
    logic        rst = 1'b1;
    logic        hw_start = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        wdg_rst_req;

    int checks = 0;
    int fails  = 0;

    localparam int NVEC = 6;
    localparam int VPSC [NVEC] = '{0, 1, 2, 6, 7, 3};
    localparam int VRLD [NVEC] = '{3, 2, 1, 0, 0, 5};
    localparam int VDIV [NVEC] = '{4, 8, 16, 256, 256, 32};

    always #4  clk  = ~clk;
    always #20 sclk = ~sclk;

    keyed_watchdog uut (
        .clk         (clk),
        .rst         (rst),
        .sclk        (sclk),
        .hw_start    (hw_start),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .wdg_rst_req (wdg_rst_req)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_we    = 1'b1;
        bus_addr  = 2'(a);
        bus_wdata = 16'(d);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk);
        bus_addr = 2'(a);
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic do_reset(input bit hw);
        hw_start = hw;
        rst = 1'b1;
        repeat (4) @(posedge sclk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int v = -1;
        for (int i = 0; i < 200; i++) begin
            rd(3, v);
            if (v == 0) break;
        end
        chk(v == 0, req, v, 0);
    endtask

    // Slow cycles until the request is seen; cap+1 when it never comes.
    task automatic measure(input int cap, output int m);
        bit seen = 1'b0;
        m = 0;
        while (m < cap && !seen) begin
            @(negedge sclk);
            m++;
            if (wdg_rst_req) seen = 1'b1;
        end
        if (!seen) m = cap + 1;
    endtask

    initial begin
        #1_200_000;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int v;
        int m;
        int e;

        do_reset(1'b0);

        // R1: reset state
        rd(1, v); chk(v == 0, "R1 prescaler after reset", v, 0);
        rd(2, v); chk(v == 12'hFFF, "R1 reload after reset", v, 12'hFFF);
        rd(3, v); chk(v == 0, "R1 status after reset", v, 0);
        chk(wdg_rst_req == 1'b0, "R1 request low", int'(wdg_rst_req), 0);

        // R4: loaded counter does not expire before start
        wr(0, 16'h5555);
        wr(1, 0);
        wr(2, 0);
        wait_idle("R8 flags clear before start test");
        wr(0, 16'hAAAA);
        measure(60, m);
        chk(m == 61, "R4 no timeout before start", m, 61);
        wr(0, 16'hCCCC);
        measure(30, m);
        chk(m <= 30, "R4 start key runs the counter", m, 30);
        @(negedge sclk);
        chk(!wdg_rst_req, "R7 pulse one slow cycle", int'(wdg_rst_req), 0);
        wr(2, 9);
        rd(2, v); chk(v == 0, "R4 start key relocks", v, 0);

        // Vector table: timeout period per prescaler/reload pair
        for (int i = 0; i < NVEC; i++) begin
            e = (VRLD[i] + 1) * VDIV[i];
            wr(0, 16'h5555);
            wr(1, VPSC[i]);
            wr(2, VRLD[i]);
            wait_idle("R8 flags clear after table writes");
            rd(1, v); chk(v == VPSC[i], "R2 prescaler readback", v, VPSC[i]);
            rd(2, v); chk(v == VRLD[i], "R2 reload readback", v, VRLD[i]);
            wr(0, 16'hAAAA);
            measure(e + 50, m);
            chk(m >= e + 1 && m <= e + 5, "R5 R6 timeout period", m, e + 3);
            @(negedge sclk);
            chk(!wdg_rst_req, "R7 pulse one slow cycle", int'(wdg_rst_req), 0);
            measure(2 * e + 20, m);
            chk(m == 2 * e + 21, "R7 restart from 0xFFF", m, 2 * e + 21);
        end

        // R3: the reload key left the registers locked
        wr(2, 7);
        rd(2, v); chk(v == 5, "R3 reload key relocks", v, 5);

        // R2: another key value relocks
        wr(0, 16'h5555);
        wr(0, 16'h1234);
        wr(1, 5);
        rd(1, v); chk(v == 3, "R2 other key relocks", v, 3);

        // R8: busy flag and write dropped while busy
        wr(0, 16'h5555);
        wr(1, 2);
        rd(3, v); chk(v == 1, "R8 prescaler busy flag", v, 1);
        wr(1, 6);
        wait_idle("R8 flag clears");
        rd(1, v); chk(v == 2, "R8 write while busy dropped", v, 2);
        wr(2, 4);
        rd(3, v); chk(v == 2, "R8 reload busy flag", v, 2);
        wait_idle("R8 reload flag clears");

        // R4: still running after other keys, including a fresh reload
        wr(0, 16'h0000);
        wr(0, 16'hFFFF);
        wr(0, 16'h5555);
        wr(1, 0);
        wr(2, 1);
        wait_idle("R8 flags clear before key test");
        wr(0, 16'hAAAA);
        measure(60, m);
        chk(m >= 9 && m <= 13, "R4 cannot be stopped", m, 11);

        // R9: hardware start, no start key
        do_reset(1'b1);
        wr(0, 16'h5555);
        wr(1, 0);
        wr(2, 2);
        wait_idle("R8 flags clear before hardware start test");
        wr(0, 16'hAAAA);
        measure(60, m);
        chk(m >= 13 && m <= 17, "R9 hardware start times out", m, 15);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule